// File: doc/BRIEF.md
# Protective Mode Supervisor and Gating

This controller supervises a three-function line protector. On every sample strobe, which arrives at a 1 kHz rate, it reads a set of flags prepared by an analog front end. Two of them are three-level deviation indicators, one for bus voltage and one for line current. The others are the half-cycle polarity, a ferroresonance detect flag, a DC-link-full flag and a fault-cleared flag. From these it picks one operating mode. It then drives eight switch gates, which form two four-switch bridges, so that the DC link is charged, inserted in series, or held out of circuit.

When a protective mode is selected, it stays latched. Later detections cannot displace it. It is released only when the fault-cleared flag is seen. The release passes through a one-sample all-off recovery step and then returns to normal. Mode and gates are registered on the same strobe that carries the flags, so a decision takes one sample period. That is far less than half a line cycle. Gate pairs within a bridge never switch directly from one pair to the other. Each such change passes through one sample with all gates off.

Top module: `prot_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 0 (normal) and `gate_o` is all zero.
- R2: In normal mode with `link_full` low, the gates request pair g5/g6 (`gate_o` = 8'h30) when `pos_half` is 1 and pair g7/g8 (8'hC0) when it is 0; gate gN is `gate_o` bit N-1.
- R3: In normal mode with `link_full` high, every gate is off.
- R4: In normal mode, a sample selects its mode by priority. Current indicator 2 selects current limiting (mode 3). Otherwise `ferro_det` high selects ferroresonance limiting (mode 4). Otherwise voltage indicator 2 (above reference) selects swell compensation (mode 2). Otherwise voltage indicator 1 (below reference) selects sag compensation (mode 1). Otherwise the mode stays normal; indicator codes 0 and 3 count as in band.
- R5: While in modes 1 to 4, samples without `fault_clr` leave the mode unchanged, whatever the indicators say.
- R6: A sample with `fault_clr` in modes 1 to 4 enters recovery (mode 5) with all gates off. The next sample always enters normal and applies the normal gating, without mode selection.
- R7: In sag compensation, g1/g2 (8'h03) are requested in the positive half cycle and g3/g4 (8'h0C) in the negative one; g5 to g8 stay off.
- R8: In swell compensation, g3/g4 are requested in the positive half cycle and g1/g2 in the negative one.
- R9: In ferroresonance limiting, g7/g8 are requested in the positive half cycle and g5/g6 in the negative one; g1 to g4 stay off.
- R10: In current limiting, every gate is off.
- R11: If a different pair is requested while another pair is on, the outputs go all off for that sample; the new pair turns on at the next sample.
- R12: Mode and gates change only on a clock edge where `sample_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle strobe marking a new sample |
| v_ind | input | 2 | Voltage deviation indicator: 0 in band, 1 low, 2 high |
| i_ind | input | 2 | Current deviation indicator: 0 in band, 1 low, 2 high |
| ferro_det | input | 1 | Ferroresonance detected |
| pos_half | input | 1 | 1 in the positive half cycle, 0 in the negative |
| link_full | input | 1 | DC link fully charged |
| fault_clr | input | 1 | Disturbance has cleared |
| mode_o | output | 3 | Active mode: 0 normal, 1 sag, 2 swell, 3 current limit, 4 ferroresonance, 5 recovery |
| gate_o | output | 8 | Gate drives g1 (bit 0) to g8 (bit 7) |

## Verification
Two behaviours can coincide on one sample. The first is mode entry and the break-before-make gap: when a fault arrives while the normal-mode charging pair is on, the new mode is latched at once, but the gates must still go all off for that sample. The second is release and selection: a sample that carries `fault_clr` together with fresh fault indicators must enter recovery and not a new mode. Likewise, the sample after recovery must ignore any indicators it carries. The vector table builds each of these collisions, and the expected mode and gate word is compared one edge after every strobe.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [2:0] {
    M_NORMAL  = 3'd0,
    M_SAG     = 3'd1,
    M_SWELL   = 3'd2,
    M_ILIMIT  = 3'd3,
    M_FERRO   = 3'd4,
    M_RECOVER = 3'd5
  } mode_e;

  localparam int IND_W    = 2;
  localparam int N_PAIRS  = 4;
  localparam int PAIR_W   = 2;
  localparam int GATE_W   = N_PAIRS * PAIR_W;

  // pair indices: A=g1/g2, B=g3/g4, C=g5/g6, D=g7/g8
  localparam logic [1:0] PAIR_A = 2'd0;
  localparam logic [1:0] PAIR_B = 2'd1;
  localparam logic [1:0] PAIR_C = 2'd2;
  localparam logic [1:0] PAIR_D = 2'd3;

  localparam logic [IND_W-1:0] IND_LOW  = 2'd1;
  localparam logic [IND_W-1:0] IND_HIGH = 2'd2;
endpackage

// File: rtl/prot_mode_select.sv
module prot_mode_select
  import prot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp,
  input  logic [IND_W-1:0] v_ind,
  input  logic [IND_W-1:0] i_ind,
  input  logic             ferro,
  input  logic             clr,
  output mode_e            mode_d,
  output mode_e            mode_q
);
  logic protective;
  assign protective = (mode_q == M_SAG) || (mode_q == M_SWELL) ||
                      (mode_q == M_ILIMIT) || (mode_q == M_FERRO);

  always_comb begin
    mode_d = mode_q;
    if (smp) begin
      unique case (mode_q)
        M_NORMAL: begin
          if (i_ind == IND_HIGH)      mode_d = M_ILIMIT;
          else if (ferro)             mode_d = M_FERRO;
          else if (v_ind == IND_HIGH) mode_d = M_SWELL;
          else if (v_ind == IND_LOW)  mode_d = M_SAG;
          else                        mode_d = M_NORMAL;
        end
        M_RECOVER: mode_d = M_NORMAL;
        default: begin
          if (clr) mode_d = M_RECOVER;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_NORMAL;
    else if (smp) mode_q <= mode_d;
  end

  // R5: latched protective mode holds without clear
  a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (smp && protective && !clr) |=> (mode_q == $past(mode_q)));
  // R6: recovery always lasts exactly one sample
  a_r6_recover_to_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (smp && mode_q == M_RECOVER) |=> (mode_q == M_NORMAL));
  // R6: recovery only entered from a protective mode with clear
  a_r6_recover_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (smp && mode_q == M_NORMAL) |=> (mode_q != M_RECOVER));
  // R12: no strobe, no mode change
  a_r12_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !smp |=> $stable(mode_q));
endmodule

// File: rtl/prot_gate_map.sv
module prot_gate_map
  import prot_pkg::*;
(
  input  mode_e              mode,
  input  logic               pos,
  input  logic               full,
  output logic [GATE_W-1:0]  want
);
  logic       on;
  logic [1:0] sel;

  always_comb begin
    on  = 1'b0;
    sel = PAIR_A;
    unique case (mode)
      M_NORMAL: begin
        on  = !full;
        sel = pos ? PAIR_C : PAIR_D;
      end
      M_SAG: begin
        on  = 1'b1;
        sel = pos ? PAIR_A : PAIR_B;
      end
      M_SWELL: begin
        on  = 1'b1;
        sel = pos ? PAIR_B : PAIR_A;
      end
      M_FERRO: begin
        on  = 1'b1;
        sel = pos ? PAIR_D : PAIR_C;
      end
      default: begin
        on  = 1'b0;
        sel = PAIR_A;
      end
    endcase
  end

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    assign want[p*PAIR_W +: PAIR_W] = (on && sel == p[1:0]) ? '1 : '0;
  end
endmodule

// File: rtl/prot_gate_reg.sv
module prot_gate_reg
  import prot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp,
  input  mode_e             mode_now,
  input  logic [GATE_W-1:0] want,
  output logic [GATE_W-1:0] gate_q
);
  logic [GATE_W-1:0] gate_d;
  logic              conflict;

  assign conflict = (gate_q != '0) && (want != '0) && (gate_q != want);
  assign gate_d   = conflict ? '0 : want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= '0;
    else if (smp) gate_q <= gate_d;
  end

  logic [N_PAIRS-1:0] pair_on;
  for (genvar p = 0; p < N_PAIRS; p++) begin : g_on
    assign pair_on[p] = |gate_q[p*PAIR_W +: PAIR_W];
  end

  // R11: at most one pair conducting
  a_r11_one_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pair_on));
  // R11: no direct pair-to-pair transfer
  a_r11_break_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (smp && gate_q != '0) |=> (gate_q == '0 || gate_q == $past(gate_q)));
  // R10: current limiting keeps all gates off
  a_r10_ilimit_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == M_ILIMIT || mode_now == M_RECOVER) |-> (gate_q == '0));
  // R7: first bridge off in normal and ferroresonance modes
  a_r7_bridge_split: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == M_NORMAL || mode_now == M_FERRO) |-> (gate_q[3:0] == '0));
  // R7: second bridge off in compensation modes
  a_r7_comp_no_link: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == M_SAG || mode_now == M_SWELL) |-> (gate_q[7:4] == '0));
  // R12: no strobe, no gate change
  a_r12_gate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !smp |=> $stable(gate_q));
endmodule

// File: rtl/prot_mode_ctrl.sv
module prot_mode_ctrl
  import prot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_en,
  input  logic [1:0]  v_ind,
  input  logic [1:0]  i_ind,
  input  logic        ferro_det,
  input  logic        pos_half,
  input  logic        link_full,
  input  logic        fault_clr,
  output logic [2:0]  mode_o,
  output logic [7:0]  gate_o
);
  mode_e             mode_d;
  mode_e             mode_q;
  logic [GATE_W-1:0] want;

  prot_mode_select u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp    (sample_en),
    .v_ind  (v_ind),
    .i_ind  (i_ind),
    .ferro  (ferro_det),
    .clr    (fault_clr),
    .mode_d (mode_d),
    .mode_q (mode_q)
  );

  prot_gate_map u_map (
    .mode (mode_d),
    .pos  (pos_half),
    .full (link_full),
    .want (want)
  );

  prot_gate_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp      (sample_en),
    .mode_now (mode_q),
    .want     (want),
    .gate_q   (gate_o)
  );

  assign mode_o = mode_q;
endmodule

// File: tb/prot_mode_ctrl_test.sv
module prot_mode_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sample_en;
  logic [1:0] v_ind, i_ind;
  logic       ferro_det, pos_half, link_full, fault_clr;
  logic [2:0] mode_o;
  logic [7:0] gate_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  prot_mode_ctrl uut (.*);

  // vector: v(2) i(2) ferro pos full clr | mode(3) gates(8) | req(8)
  localparam int NV = 27;
  typedef logic [26:0] vec_t;
  localparam vec_t VEC [NV] = '{
    {2'd0,2'd0,1'b0,1'b1,1'b0,1'b0, 3'd0, 8'h30, 8'd2},  // R2 positive charge
    {2'd0,2'd0,1'b0,1'b1,1'b0,1'b0, 3'd0, 8'h30, 8'd2},
    {2'd0,2'd0,1'b0,1'b0,1'b0,1'b0, 3'd0, 8'h00, 8'd11}, // R11 gap
    {2'd0,2'd0,1'b0,1'b0,1'b0,1'b0, 3'd0, 8'hC0, 8'd2},  // R2 negative charge
    {2'd0,2'd0,1'b0,1'b0,1'b1,1'b0, 3'd0, 8'h00, 8'd3},  // R3 full
    {2'd0,2'd0,1'b0,1'b1,1'b1,1'b0, 3'd0, 8'h00, 8'd3},  // R3 full
    {2'd1,2'd0,1'b0,1'b1,1'b0,1'b0, 3'd1, 8'h03, 8'd7},  // R7 sag positive
    {2'd0,2'd0,1'b0,1'b1,1'b0,1'b0, 3'd1, 8'h03, 8'd5},  // R5 latched
    {2'd0,2'd2,1'b1,1'b0,1'b0,1'b0, 3'd1, 8'h00, 8'd5},  // R5 ignore, R11 gap
    {2'd0,2'd0,1'b0,1'b0,1'b0,1'b0, 3'd1, 8'h0C, 8'd7},  // R7 sag negative
    {2'd0,2'd0,1'b0,1'b0,1'b0,1'b1, 3'd5, 8'h00, 8'd6},  // R6 recovery
    {2'd2,2'd2,1'b0,1'b1,1'b0,1'b0, 3'd0, 8'h30, 8'd6},  // R6 back to normal
    {2'd2,2'd0,1'b0,1'b1,1'b0,1'b0, 3'd2, 8'h00, 8'd11}, // R11 gap on entry
    {2'd2,2'd0,1'b0,1'b1,1'b0,1'b0, 3'd2, 8'h0C, 8'd8},  // R8 swell positive
    {2'd0,2'd0,1'b0,1'b0,1'b0,1'b0, 3'd2, 8'h00, 8'd11},
    {2'd0,2'd0,1'b0,1'b0,1'b0,1'b0, 3'd2, 8'h03, 8'd8},  // R8 swell negative
    {2'd0,2'd0,1'b0,1'b0,1'b0,1'b1, 3'd5, 8'h00, 8'd6},
    {2'd0,2'd0,1'b0,1'b0,1'b1,1'b0, 3'd0, 8'h00, 8'd6},
    {2'd2,2'd0,1'b1,1'b1,1'b0,1'b0, 3'd4, 8'hC0, 8'd4},  // R4 ferro over swell
    {2'd0,2'd0,1'b0,1'b0,1'b0,1'b0, 3'd4, 8'h00, 8'd11},
    {2'd0,2'd0,1'b0,1'b0,1'b0,1'b0, 3'd4, 8'h30, 8'd9},  // R9 ferro negative
    {2'd2,2'd2,1'b1,1'b1,1'b0,1'b1, 3'd5, 8'h00, 8'd6},  // R6 clear wins
    {2'd1,2'd2,1'b1,1'b1,1'b0,1'b0, 3'd0, 8'h30, 8'd6},  // R6 no selection
    {2'd1,2'd2,1'b1,1'b1,1'b0,1'b0, 3'd3, 8'h00, 8'd4},  // R4 current first
    {2'd0,2'd0,1'b0,1'b0,1'b0,1'b0, 3'd3, 8'h00, 8'd10}, // R10 all off
    {2'd0,2'd0,1'b0,1'b0,1'b0,1'b1, 3'd5, 8'h00, 8'd6},
    {2'd3,2'd3,1'b0,1'b1,1'b0,1'b0, 3'd0, 8'h30, 8'd4}   // R4 code 3 in band
  };

  task automatic expect_out(input int req, input logic [2:0] em, input logic [7:0] eg);
    checks++;
    if (mode_o !== em || gate_o !== eg) begin
      errors++;
      $display("FAIL R%0d mode=%0d gates=%h expected mode=%0d gates=%h",
               req, mode_o, gate_o, em, eg);
    end
  endtask

  task automatic strobe(input logic [1:0] v, input logic [1:0] i, input logic fr,
                        input logic p, input logic fu, input logic cl);
    @(negedge clk);
    v_ind = v; i_ind = i; ferro_det = fr; pos_half = p; link_full = fu; fault_clr = cl;
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sample_en = 1'b0;
    v_ind = '0; i_ind = '0; ferro_det = 1'b0; pos_half = 1'b0;
    link_full = 1'b0; fault_clr = 1'b0;
    repeat (3) @(negedge clk);
    expect_out(1, 3'd0, 8'h00);  // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    expect_out(1, 3'd0, 8'h00);  // R1 after release

    for (int k = 0; k < NV; k++) begin
      strobe(VEC[k][26:25], VEC[k][24:23], VEC[k][22], VEC[k][21], VEC[k][20], VEC[k][19]);
      expect_out(int'(VEC[k][7:0]), VEC[k][18:16], VEC[k][15:8]);
    end

    // R12: inputs move without a strobe
    @(negedge clk);
    v_ind = 2'd1; i_ind = 2'd2; ferro_det = 1'b1; pos_half = 1'b0; fault_clr = 1'b1;
    repeat (5) @(negedge clk);
    expect_out(12, 3'd0, 8'h30);

    // R12 then enter sag; hold through idle cycles with clear asserted
    strobe(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out(11, 3'd1, 8'h00);  // R11 gap C->B
    @(negedge clk);
    fault_clr = 1'b1;
    repeat (4) @(negedge clk);
    expect_out(12, 3'd1, 8'h00);

    // R1: reset from a protective mode
    rst_n = 1'b0;
    @(negedge clk);
    expect_out(1, 3'd0, 8'h00);
    rst_n = 1'b1;
    strobe(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out(2, 3'd0, 8'hC0);   // R2 charging after reset

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule